// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block turns a single word read from a flash address window into a complete serial flash read, with no software work per access. When the mapping enable input is high, a request on the read port starts a chip-select-framed sequence on the serial pins. The sequence has an optional opcode byte, zero to four address bytes sent most-significant byte first, an optional run of dummy clocks, and a fixed number of data bytes. The assembled word goes back to the requester on a one-cycle valid pulse.

The shape of the sequence comes from a 32-bit transfer-control word and an opcode byte. The engine captures both when it accepts a request. The control word sets the data lane width, the fast-read flag, the address byte count, whether an opcode byte is sent, and a 4-bit dummy clock count. The opcode is always sent on one lane. Address bytes use the programmed lane width only for the dual and quad I/O read opcodes, and use one lane for every other opcode. The engine drives one chip-select, and the serial clock runs at half the block clock in mode 0: data is driven while the clock is low and sampled on its rising edge. A request made while mapping is disabled gets an error reply and produces no serial activity.

Top module: `flmm_read_engine`

## Requirements
- R1: While reset is asserted and whenever no sequence is running, `spi_cs_n` is 1, `spi_sck` is 0, `spi_io_oe` is 0 and `rd_valid` is 0.
- R2: A request with `mm_en` low, made while idle, gets `rd_valid`=1 with `rd_err`=1 and `rd_data`=0 in the cycle right after the request edge. `spi_cs_n` never falls for it.
- R3: If control bit 11 is 1, the sequence starts with 8 clocks carrying `cfg_rd_opcode` MSB first on `spi_io_o[0]` with `spi_io_oe`=4'b0001. If bit 11 is 0, no opcode clocks are sent.
- R4: Control bits [10:8] give the address byte count N. Values 0 to 4 are used as given and values above 4 are used as 4. The low N bytes of `rd_addr` are sent, most significant byte first.
- R5: Address bits go out on the data lane width, with `spi_io_oe` set to 4'b0011 or 4'b1111, when the opcode is 0xBB, 0xEB, 0xBC or 0xEC. For every other opcode they go out on `spi_io_o[0]` with `spi_io_oe`=4'b0001. During dummy and data clocks `spi_io_oe`=0.
- R6: If fast bit 3 is 1, control bits [19:16] give the number of dummy clocks, from 0 to 15. If bit 3 is 0, no dummy clocks are sent, whatever that field holds.
- R7: Control bits [5:4] select the data lanes: 0 is one lane read on `spi_io_i[1]`, 1 is two lanes on `spi_io_i[1:0]`, and 2 or 3 is four lanes on `spi_io_i[3:0]`. The higher lane carries the earlier bit, bytes arrive MSB first, and the first byte lands in `rd_data[7:0]`.
- R8: With S serial clocks in the sequence, `rd_valid` (with `rd_err`=0) pulses for one cycle exactly 2*S cycles after the accepting edge. `spi_cs_n` returns to 1 in that same cycle, and `spi_sck` alternates low then high on every cycle while `spi_cs_n` is 0.
- R9: Requests arriving while a sequence runs are ignored. Changes to `mm_en`, the control word or the opcode during a sequence do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_en | input | 1 | Memory-mapped read enable |
| cfg_xfer_ctrl | input | 32 | Transfer-control word: lanes [5:4], fast [3], address bytes [10:8], opcode present [11], dummy clocks [19:16] |
| cfg_rd_opcode | input | 8 | Read opcode sent in the command phase |
| rd_req | input | 1 | Single-cycle read request, taken when idle |
| rd_addr | input | ADDR_W | Flash byte address of the request |
| rd_valid | output | 1 | Response strobe, one cycle |
| rd_err | output | 1 | Response is an error (mapping disabled) |
| rd_data | output | 8*DATA_BYTES | Returned data, first byte in the lowest lane; zero outside a valid data response |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_io_o | output | 4 | Serial data out, per lane |
| spi_io_oe | output | 4 | Output enable, per lane |
| spi_io_i | input | 4 | Serial data in, per lane |

## Verification
A data response is due 2*S cycles after the accepting edge. S is the opcode clocks, plus address bits divided by the address lane count, plus dummy clocks, plus data bits divided by the data lane count. An error response is due in the first cycle after the edge. The bench computes S from the requirements for every request. It counts falling clock edges from the accepting edge until `rd_valid` appears, compares that count with 2*S, and reads the data, `rd_err` and the chip-select state on that same falling edge. One edge later it checks that the pulse has ended. A bench flash model counts rising `spi_sck` edges on its own to split the sequence into opcode, address, dummy and data clocks, and checks the captured opcode, address and output enables when chip-select rises.

// File: rtl/flmm_pkg.sv
package flmm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_ADR  = 3'd2,
    ST_DMY  = 3'd3,
    ST_DAT  = 3'd4
  } seq_state_e;

  // Decoded sequence shape; lane fields hold log2 of the lane count.
  typedef struct packed {
    logic       with_cmd;
    logic [2:0] addr_bytes;
    logic [3:0] dummy;
    logic [1:0] adr_sh;
    logic [1:0] dat_sh;
  } seq_cfg_t;

  function automatic logic [1:0] lane_shift(input logic [1:0] fld);
    case (fld)
      2'd0:    lane_shift = 2'd0;
      2'd1:    lane_shift = 2'd1;
      default: lane_shift = 2'd2;
    endcase
  endfunction

  // Opcodes whose address phase also uses the wide data lanes.
  function automatic logic wide_addr_op(input logic [7:0] op);
    case (op)
      8'hBB, 8'hEB, 8'hBC, 8'hEC: wide_addr_op = 1'b1;
      default:                    wide_addr_op = 1'b0;
    endcase
  endfunction

  function automatic seq_cfg_t decode_cfg(
    input logic       with_cmd,
    input logic [2:0] nab_fld,
    input logic       fast,
    input logic [3:0] dmy_fld,
    input logic [1:0] lane_fld,
    input logic [7:0] op
  );
    seq_cfg_t c;
    c.with_cmd   = with_cmd;
    c.addr_bytes = (nab_fld > 3'd4) ? 3'd4 : nab_fld;
    c.dummy      = fast ? dmy_fld : 4'd0;
    c.dat_sh     = lane_shift(lane_fld);
    c.adr_sh     = wide_addr_op(op) ? c.dat_sh : 2'd0;
    return c;
  endfunction

endpackage

// File: rtl/flmm_seq.sv
module flmm_seq
  import flmm_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  seq_cfg_t   cfg_in,
  output logic       accept,
  output logic       idle,
  output seq_state_e state,
  output logic       phase_hi,
  output seq_cfg_t   cfg_q,
  output logic       beat_end,
  output logic       xfer_done
);

  localparam int MAXB  = (DATA_BYTES * 8 > 32) ? DATA_BYTES * 8 : 32;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int BW    = CNT_W + 1;

  seq_state_e st_q, st_d;
  logic       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  seq_cfg_t   cfg_d;
  seq_state_e nxt_first, nxt_run;
  logic       last_beat;

  function automatic logic [BW-1:0] beats(input seq_state_e s, input seq_cfg_t c);
    case (s)
      ST_CMD:  beats = BW'(8);
      ST_ADR:  beats = BW'({c.addr_bytes, 3'b000}) >> c.adr_sh;
      ST_DMY:  beats = BW'(c.dummy);
      ST_DAT:  beats = BW'(DATA_BYTES * 8) >> c.dat_sh;
      default: beats = BW'(1);
    endcase
  endfunction

  function automatic seq_state_e follow(input seq_state_e s, input seq_cfg_t c);
    seq_state_e after_cmd;
    after_cmd = (c.addr_bytes != 3'd0) ? ST_ADR :
                (c.dummy != 4'd0)      ? ST_DMY : ST_DAT;
    case (s)
      ST_IDLE: follow = c.with_cmd ? ST_CMD : after_cmd;
      ST_CMD:  follow = after_cmd;
      ST_ADR:  follow = (c.dummy != 4'd0) ? ST_DMY : ST_DAT;
      default: follow = ST_DAT;
    endcase
  endfunction

  always_comb begin
    idle      = (st_q == ST_IDLE);
    accept    = idle & start;
    nxt_first = follow(ST_IDLE, cfg_in);
    nxt_run   = follow(st_q, cfg_q);
    beat_end  = ~idle & ph_q;
    last_beat = beat_end & (cnt_q == '0);
    xfer_done = last_beat & (st_q == ST_DAT);
  end

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    cfg_d = cfg_q;
    if (idle) begin
      ph_d = 1'b0;
      if (start) begin
        cfg_d = cfg_in;
        st_d  = nxt_first;
        cnt_d = CNT_W'(beats(nxt_first, cfg_in) - 1'b1);
      end
    end else begin
      ph_d = ~ph_q;
      if (ph_q) begin
        if (cnt_q == '0) begin
          st_d  = (st_q == ST_DAT) ? ST_IDLE : nxt_run;
          cnt_d = CNT_W'(beats(nxt_run, cfg_q) - 1'b1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (accept) cfg_q <= cfg_d;
    end
  end

  assign state    = st_q;
  assign phase_hi = ph_q;

endmodule

// File: rtl/flmm_txshift.sv
module flmm_txshift
  import flmm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  seq_cfg_t    load_cfg,
  input  logic [7:0]  opcode,
  input  logic [31:0] addr,
  input  logic        shift_en,
  input  logic [1:0]  lane_sh,
  output logic [3:0]  io_o
);

  logic [39:0] tx_q, tx_d;
  logic [31:0] aligned;
  logic [5:0]  pad;

  always_comb begin
    pad     = {3'(3'd4 - load_cfg.addr_bytes), 3'b000};
    aligned = addr << pad;
    tx_d    = tx_q;
    if (load) begin
      tx_d = load_cfg.with_cmd ? {opcode, aligned} : {aligned, 8'h00};
    end else if (shift_en) begin
      case (lane_sh)
        2'd0:    tx_d = tx_q << 1;
        2'd1:    tx_d = tx_q << 2;
        default: tx_d = tx_q << 4;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  always_comb begin
    case (lane_sh)
      2'd0:    io_o = {3'b000, tx_q[39]};
      2'd1:    io_o = {2'b00, tx_q[39:38]};
      default: io_o = tx_q[39:36];
    endcase
  end

endmodule

// File: rtl/flmm_rxassemble.sv
module flmm_rxassemble #(
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    sample,
  input  logic [1:0]              lane_sh,
  input  logic [3:0]              io_i,
  output logic [DATA_BYTES*8-1:0] word
);

  localparam int WORD_W = DATA_BYTES * 8;
  localparam int IDX_W  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  logic [7:0]        acc_q, acc_d, nb;
  logic [3:0]        fill_q, fill_d, fill_nx;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    case (lane_sh)
      2'd0:    nb = {acc_q[6:0], io_i[1]};
      2'd1:    nb = {acc_q[5:0], io_i[1:0]};
      default: nb = {acc_q[3:0], io_i[3:0]};
    endcase
    fill_nx = fill_q + (4'd1 << lane_sh);
    acc_d   = acc_q;
    fill_d  = fill_q;
    idx_d   = idx_q;
    word_d  = word_q;
    if (clear) begin
      acc_d  = '0;
      fill_d = '0;
      idx_d  = '0;
      word_d = '0;
    end else if (sample) begin
      acc_d = nb;
      if (fill_nx == 4'd8) begin
        fill_d = '0;
        word_d[idx_q*8 +: 8] = nb;
        idx_d  = idx_q + 1'b1;
      end else begin
        fill_d = fill_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      idx_q  <= idx_d;
      word_q <= word_d;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/flmm_read_engine.sv
module flmm_read_engine
  import flmm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mm_en,
  input  logic [31:0]             cfg_xfer_ctrl,
  input  logic [7:0]              cfg_rd_opcode,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_valid,
  output logic                    rd_err,
  output logic [DATA_BYTES*8-1:0] rd_data,
  output logic                    spi_cs_n,
  output logic                    spi_sck,
  output logic [3:0]              spi_io_o,
  output logic [3:0]              spi_io_oe,
  input  logic [3:0]              spi_io_i
);

  localparam int WORD_W = DATA_BYTES * 8;

  seq_cfg_t    cfg_in, cfg_q;
  seq_state_e  state;
  logic        accept, idle, phase_hi, beat_end, xfer_done;
  logic        err_req;
  logic        valid_q, valid_d, err_q, err_d;
  logic [31:0] addr32;
  logic [WORD_W-1:0] word;
  logic [1:0]  tx_lane;
  logic        ctrl_unused;

  assign ctrl_unused = ^{cfg_xfer_ctrl[31:20], cfg_xfer_ctrl[7:6], cfg_xfer_ctrl[2:0]};
  assign addr32      = 32'(rd_addr);
  assign cfg_in      = decode_cfg(cfg_xfer_ctrl[11], cfg_xfer_ctrl[10:8], cfg_xfer_ctrl[3],
                                  cfg_xfer_ctrl[19:16], cfg_xfer_ctrl[5:4], cfg_rd_opcode);

  flmm_seq #(.DATA_BYTES(DATA_BYTES)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_req & mm_en),
    .cfg_in    (cfg_in),
    .accept    (accept),
    .idle      (idle),
    .state     (state),
    .phase_hi  (phase_hi),
    .cfg_q     (cfg_q),
    .beat_end  (beat_end),
    .xfer_done (xfer_done)
  );

  assign tx_lane = (state == ST_CMD) ? 2'd0 : cfg_q.adr_sh;

  flmm_txshift tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_cfg (cfg_in),
    .opcode   (cfg_rd_opcode),
    .addr     (addr32),
    .shift_en (beat_end & ((state == ST_CMD) | (state == ST_ADR))),
    .lane_sh  (tx_lane),
    .io_o     (spi_io_o)
  );

  flmm_rxassemble #(.DATA_BYTES(DATA_BYTES)) rx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .sample  (beat_end & (state == ST_DAT)),
    .lane_sh (cfg_q.dat_sh),
    .io_i    (spi_io_i),
    .word    (word)
  );

  always_comb begin
    err_req = rd_req & ~mm_en & idle;
    valid_d = xfer_done | err_req;
    err_d   = err_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    case (state)
      ST_CMD: spi_io_oe = 4'b0001;
      ST_ADR: begin
        case (cfg_q.adr_sh)
          2'd0:    spi_io_oe = 4'b0001;
          2'd1:    spi_io_oe = 4'b0011;
          default: spi_io_oe = 4'b1111;
        endcase
      end
      default: spi_io_oe = 4'b0000;
    endcase
  end

  assign spi_cs_n = idle;
  assign spi_sck  = ~idle & phase_hi;
  assign rd_valid = valid_q;
  assign rd_err   = err_q;
  assign rd_data  = word & {WORD_W{valid_q & ~err_q}};

endmodule

// File: rtl/flmm_read_engine_chk.sv
module flmm_read_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mm_en,
  input logic                    rd_req,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic                    rd_valid,
  input logic                    rd_err,
  input logic [DATA_BYTES*8-1:0] rd_data,
  input logic                    spi_cs_n,
  input logic                    spi_sck,
  input logic [3:0]              spi_io_oe
);

  logic addr_unused;
  assign addr_unused = ^rd_addr;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sck && spi_io_oe == 4'b0000)); // R1

  AST_ERR_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !mm_en && spi_cs_n) |=> (rd_valid && rd_err && rd_data == '0)); // R2

  AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !mm_en && spi_cs_n) |=> spi_cs_n); // R2

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe == 4'b0000 || spi_io_oe == 4'b0001 || spi_io_oe == 4'b0011 || spi_io_oe == 4'b1111)); // R5

  AST_SCK_HIGH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !spi_sck) |=> spi_sck); // R8

  AST_SCK_LOW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sck) |=> !spi_sck); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_err) |-> (spi_cs_n && $past(!spi_cs_n))); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && rd_req) |=> !rd_err); // R9

endmodule

bind flmm_read_engine flmm_read_engine_chk #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mm_en     (mm_en),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_valid  (rd_valid),
  .rd_err    (rd_err),
  .rd_data   (rd_data),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .spi_io_oe (spi_io_oe)
);

// File: tb/flmm_read_engine_tb_top.sv
module flmm_read_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mm_en = 1'b0;
  logic [31:0] cfg_xfer_ctrl = '0;
  logic [7:0]  cfg_rd_opcode = '0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_valid, rd_err;
  logic [31:0] rd_data;
  logic        spi_cs_n, spi_sck;
  logic [3:0]  spi_io_o, spi_io_oe;
  logic [3:0]  spi_io_i = '0;

  always #2 clk = ~clk;

  flmm_read_engine dut_i (
    .clk(clk), .rst_n(rst_n), .mm_en(mm_en), .cfg_xfer_ctrl(cfg_xfer_ctrl),
    .cfg_rd_opcode(cfg_rd_opcode), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_io_o(spi_io_o),
    .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Expected shape of the running sequence
  bit          e_cmd = 1'b0;
  int          e_nab = 0, e_dmy = 0, e_al = 1, e_dl = 1;
  logic [31:0] e_addr = '0;

  function automatic logic [7:0] pat(input logic [31:0] a, input int k);
    return a[7:0] ^ 8'(8'h5A + k * 37);
  endfunction

  function automatic logic [3:0] lmask(input int n);
    return (n == 1) ? 4'b0001 : (n == 2) ? 4'b0011 : 4'b1111;
  endfunction

  // Flash model
  int          m_n = 0, m_bad = 0, cs_falls = 0;
  logic [7:0]  m_op = '0;
  logic [31:0] m_adr = '0;
  int          last_n = 0, last_bad = 0;
  logic [7:0]  last_op = '0;
  logic [31:0] last_adr = '0;
  int          cb, ab, jb, bp;
  logic [7:0]  bt;
  logic [3:0]  bv;

  always @(posedge spi_sck) begin
    cb = e_cmd ? 8 : 0;
    ab = e_nab * 8 / e_al;
    if (m_n < cb) begin
      m_op = {m_op[6:0], spi_io_o[0]};
      if (spi_io_oe != 4'b0001) m_bad++;
    end else if (m_n < cb + ab) begin
      if (e_al == 1)      m_adr = {m_adr[30:0], spi_io_o[0]};
      else if (e_al == 2) m_adr = {m_adr[29:0], spi_io_o[1:0]};
      else                m_adr = {m_adr[27:0], spi_io_o};
      if (spi_io_oe != lmask(e_al)) m_bad++;
    end else begin
      if (spi_io_oe != 4'b0000) m_bad++;
    end
    m_n++;
  end

  always @(negedge spi_sck or negedge spi_cs_n) begin
    jb = m_n - ((e_cmd ? 8 : 0) + e_nab * 8 / e_al + e_dmy);
    if (!spi_cs_n && jb >= 0 && jb < 32 / e_dl) begin
      bp = jb * e_dl;
      bt = pat(e_addr, bp / 8);
      bv = 4'((bt >> (8 - e_dl - (bp % 8)))) & lmask(e_dl);
      spi_io_i = (e_dl == 1) ? {2'b00, bv[0], 1'b0} : bv;
    end else begin
      spi_io_i = 4'b0000;
    end
  end

  always @(posedge spi_cs_n) begin
    last_n = m_n; last_op = m_op; last_adr = m_adr; last_bad = m_bad;
    m_n = 0; m_op = '0; m_adr = '0; m_bad = 0;
  end

  always @(negedge spi_cs_n) cs_falls++;

  function automatic bit is_wide(input logic [7:0] op);
    return op == 8'hBB || op == 8'hEB || op == 8'hBC || op == 8'hEC;
  endfunction

  task automatic do_read(input logic [7:0] op, input logic [31:0] ctl,
                         input logic [31:0] addr, input bit poke);
    int nabf, s, m, falls0;
    logic [31:0] exp_data, exp_adr;
    e_cmd  = ctl[11];
    nabf   = int'(ctl[10:8]);
    e_nab  = (nabf > 4) ? 4 : nabf;
    e_dmy  = ctl[3] ? int'(ctl[19:16]) : 0;
    e_dl   = (ctl[5:4] == 2'd0) ? 1 : (ctl[5:4] == 2'd1) ? 2 : 4;
    e_al   = is_wide(op) ? e_dl : 1;
    e_addr = addr;
    s = (e_cmd ? 8 : 0) + e_nab * 8 / e_al + e_dmy + 32 / e_dl;
    for (int k = 0; k < 4; k++) exp_data[k*8 +: 8] = pat(addr, k);
    exp_adr = (e_nab == 0) ? 32'h0 : (e_nab == 4) ? addr : (addr & ((32'h1 << (8 * e_nab)) - 1));
    @(negedge clk);
    falls0 = cs_falls;
    mm_en = 1'b1; cfg_xfer_ctrl = ctl; cfg_rd_opcode = op; rd_addr = addr; rd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    m = 0;
    while (!rd_valid && m < 4000) begin
      if (poke && m == 3) begin
        rd_req = 1'b1; mm_en = 1'b0; cfg_xfer_ctrl = ~ctl; cfg_rd_opcode = ~op; rd_addr = ~addr;
      end
      if (poke && m == 4) begin
        rd_req = 1'b0; mm_en = 1'b1;
      end
      @(negedge clk);
      m++;
    end
    chk(m == 2 * s, "R8", "response latency", 64'(m), 64'(2 * s));
    chk(rd_err == 1'b0, poke ? "R9" : "R8", "error flag", 64'(rd_err), 64'd0);
    chk(rd_data == exp_data, "R7", "read data", 64'(rd_data), 64'(exp_data));
    chk(spi_cs_n == 1'b1, "R8", "cs released with valid", 64'(spi_cs_n), 64'd1);
    chk(cs_falls - falls0 == 1, "R9", "one select per request", 64'(cs_falls - falls0), 64'd1);
    chk(last_n == s, "R6", "serial clock count", 64'(last_n), 64'(s));
    if (e_cmd) chk(last_op == op, "R3", "opcode bits", 64'(last_op), 64'(op));
    chk(last_adr == exp_adr, "R4", "address bits", 64'(last_adr), 64'(exp_adr));
    chk(last_bad == 0, "R5", "output enable pattern", 64'(last_bad), 64'd0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8", "single-cycle valid", 64'(rd_valid), 64'd0);
  endtask

  task automatic do_err_read(input logic [31:0] addr);
    int falls0;
    @(negedge clk);
    falls0 = cs_falls;
    mm_en = 1'b0; rd_addr = addr; rd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid && rd_err, "R2", "error response", {rd_valid, rd_err}, 64'h3);
    chk(rd_data == '0, "R2", "error data", 64'(rd_data), 64'd0);
    chk(spi_cs_n == 1'b1, "R2", "no select", 64'(spi_cs_n), 64'd1);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R2", "error pulse width", 64'(rd_valid), 64'd0);
    chk(cs_falls == falls0, "R2", "select count", 64'(cs_falls - falls0), 64'd0);
    mm_en = 1'b1;
  endtask

  function automatic logic [31:0] mk_ctl(input bit cmd, input int nab, input bit fast,
                                         input int dmy, input int lanes);
    return (32'(dmy & 15) << 16) | (32'(cmd) << 11) | (32'(nab & 7) << 8) |
           (32'(lanes & 3) << 4) | (32'(fast) << 3);
  endfunction

  logic [7:0] ops3 [6] = '{8'h03, 8'h0B, 8'h3B, 8'hBB, 8'h6B, 8'hEB};
  logic [7:0] ops4 [6] = '{8'h13, 8'h0C, 8'h3C, 8'hBC, 8'h6C, 8'hEC};
  int         t_ln [6] = '{0, 0, 1, 1, 2, 2};
  int         t_dm [6] = '{0, 8, 8, 4, 8, 6};
  bit         t_fs [6] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "pins in reset", {spi_cs_n, spi_sck}, 64'h2);
    chk(spi_io_oe == 4'b0000 && rd_valid == 1'b0, "R1", "oe/valid in reset", {spi_io_oe, rd_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_io_oe == 4'b0000, "R1", "idle after reset", {spi_cs_n, spi_io_oe}, 64'h10);

    do_err_read(32'h0000_1234);                                    // R2
    do_read(8'h03, mk_ctl(1'b0, 0, 1'b0, 0, 0), 32'h0000_00A7, 1'b0); // R3 R4: data only
    do_read(8'h0B, mk_ctl(1'b1, 3, 1'b0, 9, 0), 32'h0012_3456, 1'b0); // R6: fast off
    do_read(8'h0B, mk_ctl(1'b1, 3, 1'b1, 15, 0), 32'h00AB_CDEF, 1'b0); // R6: 15 dummies
    do_read(8'h6B, mk_ctl(1'b1, 7, 1'b1, 8, 2), 32'h89AB_CDEF, 1'b0); // R4: clipped to 4
    do_read(8'hEB, mk_ctl(1'b1, 3, 1'b1, 6, 3), 32'h0055_AA33, 1'b0); // R5 R7: field 3
    do_read(8'h3B, mk_ctl(1'b1, 1, 1'b1, 8, 1), 32'h0000_00C3, 1'b0); // R4: one byte
    do_read(8'hBB, mk_ctl(1'b1, 3, 1'b1, 4, 1), 32'h0031_4159, 1'b1); // R9: poke mid-flight

    for (int i = 0; i < 24; i++) begin
      int idx;
      bit wide;
      idx  = int'($urandom % 6);
      wide = 1'($urandom % 2);
      do_read(wide ? ops4[idx] : ops3[idx],
              mk_ctl(1'b1, wide ? 4 : 3, t_fs[idx], t_dm[idx], t_ln[idx]),
              $urandom, 1'b0);
    end

    do_err_read(32'hFFFF_0000);                                    // R2 after traffic
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule